// File: doc/BRIEF.md
# Receive Payload DWORD Realigner

This block sits on the application side of a packet receive path. The path delivers payload on a 64-bit bus, two DWORDs per clock, in little-endian lane order: lane 0 is bits [31:0] and lane 1 is bits [63:32]. The payload is naturally aligned to its address. Address bit 2 therefore decides whether the first payload DWORD arrives in lane 0 or in lane 1. The block reads that bit from the descriptor that comes with the first beat. A separate descriptor flag tells it which descriptor bit holds the address bit, depending on whether the request uses 64-bit or 32-bit addressing.

The output is a dense DWORD stream in which the first payload DWORD always sits in lane 0. Each output beat reports how many DWORDs it holds. When the input starts in lane 1, a one-DWORD holding register carries the spare upper DWORD into the next output beat. After the final input beat, any DWORD left in that register is sent by itself, without waiting for more input.

The block throttles the sender with a wait output. It raises wait whenever its output register cannot take a new beat, or while the leftover DWORD is being flushed.

Top module: `rx_dw_realign`

## Requirements
- R1: On the output, the first DWORD of a beat is on `dw_data[31:0]` and the second is on `dw_data[63:32]`. Payload DWORDs leave in payload order, starting with the first payload DWORD in the low lane of the first output beat.
- R2: The alignment bit is read from `pl_desc` on the beat with `pl_first` high. If `pl_desc[61]` is 1, it is `pl_desc[2]`; if `pl_desc[61]` is 0, it is `pl_desc[34]`. An alignment bit of 1 places the first payload DWORD in the upper lane; 0 places it in the lower lane.
- R3: On a first beat whose alignment bit is 1, the lower lane is ignored even when its byte enables are set.
- R4: Apart from the R3 case, an input lane carries a payload DWORD exactly when at least one of its four byte enables (`pl_be[3:0]` for lane 0, `pl_be[7:4]` for lane 1) is set. A lane with all enables clear is ignored.
- R5: `dw_count` is 1 or 2 whenever `dw_valid` is high. Every output beat of a payload except the final one carries 2 DWORDs.
- R6: `dw_last` is high on the final output beat of each payload and on no other beat. A DWORD left over after the final input beat is sent on the next free output cycle with count 1, and `pl_wait` is high until that has happened.
- R7: When `dw_count` is 1, `dw_data[63:32]` is zero.
- R8: While `dw_valid` is high and `dw_ready` is low, the output beat holds stable and `pl_wait` is high. A beat presented while `pl_wait` is high is not consumed, and the sender holds it until `pl_wait` drops.
- R9: A synchronous active-low reset drops `dw_valid`, clears the holding register, and leaves `pl_wait` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pl_valid | input | 1 | Input beat present |
| pl_first | input | 1 | Beat is the first of a payload; descriptor is valid |
| pl_last | input | 1 | Beat is the final one of a payload |
| pl_desc | input | 64 | Descriptor (alignment bit and address-width flag) |
| pl_data | input | 64 | Naturally aligned payload data, two DWORDs |
| pl_be | input | 8 | Byte enables, one per byte of `pl_data` |
| pl_wait | output | 1 | Wait state toward the sender; beat not consumed while high |
| dw_valid | output | 1 | Output beat present |
| dw_ready | input | 1 | Downstream accepts the output beat |
| dw_data | output | 64 | Packed DWORDs, first in the low lane |
| dw_count | output | 2 | Number of valid DWORDs in `dw_data` (1 or 2) |
| dw_last | output | 1 | Final output beat of the payload |

## Verification
The hardest case to reach is a leftover flush that meets a downstream stall. This needs a payload that starts in the upper lane and has an odd length of three or more, so that the final input beat overflows the holding register. At the same moment `dw_ready` must be low, so that the flush is itself held off. The stimulus sweeps every length from 1 to 7 against both alignments, both addressing modes and four `dw_ready` patterns. One of those patterns produces long low runs, so the collision occurs repeatedly. A decoy value is also placed in the unused descriptor bit and in the enabled lower lane of misaligned first beats. With these in place, reading the wrong bit or lane corrupts the observed stream.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef logic [1:0] dw_cnt_t;

  // Number of DWORDs available this cycle: held one plus the live lanes.
  function automatic dw_cnt_t dw_total(input logic held, input logic lane0, input logic lane1);
    return dw_cnt_t'({1'b0, held}) + dw_cnt_t'({1'b0, lane0}) + dw_cnt_t'({1'b0, lane1});
  endfunction

endpackage

// File: rtl/rxr_lane_sel.sv
module rxr_lane_sel #(
  parameter int unsigned DW_W        = 32,
  parameter int unsigned DESC_W      = 64,
  parameter int unsigned WIDE_BIT    = 61,
  parameter int unsigned ALIGN64_BIT = 2,
  parameter int unsigned ALIGN32_BIT = 34
) (
  input  logic                  first,
  input  logic [DESC_W-1:0]     desc,
  input  logic [2*(DW_W/8)-1:0] be,
  output logic                  align,
  output logic [1:0]            lane_v
);
  localparam int unsigned BPD = DW_W / 8;

  function automatic logic pick_align(input logic [DESC_W-1:0] d);
    return d[WIDE_BIT] ? d[ALIGN64_BIT] : d[ALIGN32_BIT];
  endfunction

  assign align = pick_align(desc);

  for (genvar l = 0; l < 2; l++) begin : g_lane
    // lane 0 of a first beat is skipped when the payload starts in lane 1
    logic skip;
    assign skip      = first && align && (l == 0);
    assign lane_v[l] = (|be[l*BPD +: BPD]) && !skip;
  end

endmodule

// File: rtl/rxr_pack.sv
module rxr_pack
  import rxr_pkg::*;
#(
  parameter int unsigned DW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              in_last,
  input  logic [1:0]        lane_v,
  input  logic [DW_W-1:0]   lo_dw,
  input  logic [DW_W-1:0]   hi_dw,
  input  logic              dw_ready,
  output logic              can_take,
  output logic              dw_valid,
  output logic [2*DW_W-1:0] dw_data,
  output dw_cnt_t           dw_count,
  output logic              dw_last
);
  logic            hold_v;
  logic [DW_W-1:0] hold_dw;
  logic            flush_pend;
  logic            out_free;
  dw_cnt_t         avail;
  logic [DW_W-1:0] first_dw;
  logic [DW_W-1:0] second_dw;

  assign out_free = !dw_valid || dw_ready;
  assign can_take = out_free && !flush_pend;
  assign avail    = dw_total(hold_v, lane_v[0], lane_v[1]);

  always_comb begin
    if (hold_v) begin
      first_dw  = hold_dw;
      second_dw = lane_v[0] ? lo_dw : hi_dw;
    end else begin
      first_dw  = lane_v[0] ? lo_dw : hi_dw;
      second_dw = hi_dw;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v     <= 1'b0;
      hold_dw    <= '0;
      flush_pend <= 1'b0;
      dw_valid   <= 1'b0;
      dw_data    <= '0;
      dw_count   <= '0;
      dw_last    <= 1'b0;
    end else begin
      if (dw_ready) dw_valid <= 1'b0;
      if (flush_pend && out_free) begin
        dw_valid   <= 1'b1;
        dw_data    <= {{DW_W{1'b0}}, hold_dw};
        dw_count   <= 2'd1;
        dw_last    <= 1'b1;
        hold_v     <= 1'b0;
        flush_pend <= 1'b0;
      end else if (take) begin
        unique case (avail)
          2'd1: begin
            if (in_last) begin
              dw_valid <= 1'b1;
              dw_data  <= {{DW_W{1'b0}}, first_dw};
              dw_count <= 2'd1;
              dw_last  <= 1'b1;
              hold_v   <= 1'b0;
            end else begin
              hold_dw <= first_dw;
              hold_v  <= 1'b1;
            end
          end
          2'd2: begin
            dw_valid <= 1'b1;
            dw_data  <= {second_dw, first_dw};
            dw_count <= 2'd2;
            dw_last  <= in_last;
            hold_v   <= 1'b0;
          end
          2'd3: begin
            dw_valid   <= 1'b1;
            dw_data    <= {second_dw, first_dw};
            dw_count   <= 2'd2;
            dw_last    <= 1'b0;
            hold_dw    <= hi_dw;
            hold_v     <= 1'b1;
            flush_pend <= in_last;
          end
          default: ;
        endcase
      end
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dw_valid |-> (dw_count == 2'd1 || dw_count == 2'd2)); // R5

  AST_SHORT_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_valid && dw_count == 2'd1) |-> dw_last); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_valid && !dw_ready) |=> (dw_valid && $stable(dw_data) && $stable(dw_count) && $stable(dw_last))); // R8

  AST_FLUSH_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pend && out_free) |=> (dw_valid && dw_last && dw_count == 2'd1)); // R6

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_valid && dw_count == 2'd1) |-> (dw_data[2*DW_W-1:DW_W] == '0)); // R7

endmodule

// File: rtl/rx_dw_realign.sv
module rx_dw_realign
  import rxr_pkg::*;
#(
  parameter int unsigned DW_W        = 32,
  parameter int unsigned DESC_W      = 64,
  parameter int unsigned WIDE_BIT    = 61,
  parameter int unsigned ALIGN64_BIT = 2,
  parameter int unsigned ALIGN32_BIT = 34
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pl_valid,
  input  logic                  pl_first,
  input  logic                  pl_last,
  input  logic [DESC_W-1:0]     pl_desc,
  input  logic [2*DW_W-1:0]     pl_data,
  input  logic [2*(DW_W/8)-1:0] pl_be,
  output logic                  pl_wait,
  output logic                  dw_valid,
  input  logic                  dw_ready,
  output logic [2*DW_W-1:0]     dw_data,
  output logic [1:0]            dw_count,
  output logic                  dw_last
);
  logic       align;
  logic [1:0] lane_v;
  logic       can_take;
  logic       take;
  logic       desc_unused;

  assign desc_unused = ^pl_desc;

  rxr_lane_sel #(
    .DW_W(DW_W), .DESC_W(DESC_W), .WIDE_BIT(WIDE_BIT),
    .ALIGN64_BIT(ALIGN64_BIT), .ALIGN32_BIT(ALIGN32_BIT)
  ) i_lane_sel (
    .first (pl_first),
    .desc  (pl_desc),
    .be    (pl_be),
    .align (align),
    .lane_v(lane_v)
  );

  assign take    = pl_valid && can_take;
  assign pl_wait = !can_take;

  rxr_pack #(.DW_W(DW_W)) i_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .in_last (pl_last),
    .lane_v  (lane_v),
    .lo_dw   (pl_data[DW_W-1:0]),
    .hi_dw   (pl_data[2*DW_W-1:DW_W]),
    .dw_ready(dw_ready),
    .can_take(can_take),
    .dw_valid(dw_valid),
    .dw_data (dw_data),
    .dw_count(dw_count),
    .dw_last (dw_last)
  );

  AST_ALIGNED_FIRST_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pl_first && align) |-> !lane_v[0]); // R3

  AST_STALL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_valid && !dw_ready) |-> pl_wait); // R8

endmodule

// File: tb/test_rx_dw_realign.sv
module test_rx_dw_realign;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pl_valid, pl_first, pl_last;
  logic [63:0] pl_desc, pl_data;
  logic [7:0]  pl_be;
  logic        pl_wait;
  logic        dw_valid, dw_ready, dw_last;
  logic [63:0] dw_data;
  logic [1:0]  dw_count;

  rx_dw_realign i_rx_dw_realign (
    .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_first(pl_first),
    .pl_last(pl_last), .pl_desc(pl_desc), .pl_data(pl_data), .pl_be(pl_be),
    .pl_wait(pl_wait), .dw_valid(dw_valid), .dw_ready(dw_ready),
    .dw_data(dw_data), .dw_count(dw_count), .dw_last(dw_last)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int exp_len [0:255];
  int n_sent = 0, rx_pkt = 0, rx_idx = 0, ready_mode = 0;
  bit done = 0;
  logic        prev_stall = 1'b0;
  logic [63:0] prev_data;
  logic [1:0]  prev_cnt;
  logic        prev_last;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic ready_pat(input int m, input int c);
    case (m)
      0: return 1'b1;
      1: return c[0];
      2: return (c % 5) != 0;
      default: return (c % 7) >= 4;
    endcase
  endfunction

  // monitor: drives dw_ready and checks the stream between clock edges
  always @(negedge clk) begin
    logic r;
    cyc++;
    if (cyc > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL R5 watchdog act=%0d exp=%0d payloads", rx_pkt, n_sent);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    r = ready_pat(ready_mode, cyc);
    dw_ready = r;
    if (!rst_n) prev_stall = 1'b0;
    else begin
      if (prev_stall)
        chk(dw_valid && dw_data == prev_data && dw_count == prev_cnt && dw_last == prev_last,
            "R8 stalled beat changed", dw_data, prev_data);
      if (dw_valid && r) begin
        for (int k = 0; k < int'(dw_count); k++) begin
          logic [31:0] e;
          e = {rx_pkt[15:0], rx_idx[15:0]};
          chk(dw_data[k*32 +: 32] == e, "R1/R2/R3/R4/R8 dword order", {32'h0, dw_data[k*32 +: 32]}, {32'h0, e});
          rx_idx++;
        end
        if (rx_pkt < 256) begin
          chk(dw_last == (rx_idx >= exp_len[rx_pkt]), "R6 last flag", {63'h0, dw_last}, {63'h0, rx_idx >= exp_len[rx_pkt]});
        end
        if (!dw_last) chk(dw_count == 2'd2, "R5 inner count", {62'h0, dw_count}, 64'd2);
        else chk(dw_count == 2'd1 || dw_count == 2'd2, "R5 last count", {62'h0, dw_count}, 64'd1);
        if (dw_count == 2'd1) chk(dw_data[63:32] == 32'h0, "R7 upper lane zero", {32'h0, dw_data[63:32]}, 64'h0);
        if (dw_last) begin rx_pkt++; rx_idx = 0; end
      end
      prev_stall = dw_valid && !r;
      prev_data  = dw_data;
      prev_cnt   = dw_count;
      prev_last  = dw_last;
    end
  end

  function automatic logic [63:0] make_desc(input bit a64, input bit al);
    logic [63:0] d;
    d = 64'h0;
    d[61] = a64;
    d[2]  = a64 ? al : ~al;
    d[34] = a64 ? ~al : al;
    return d;
  endfunction

  task automatic put_beat(input logic f, input logic l, input logic [63:0] d,
                          input logic [7:0] be, input logic [63:0] desc);
    bit acc;
    @(negedge clk);
    pl_valid = 1'b1; pl_first = f; pl_last = l; pl_data = d; pl_be = be; pl_desc = desc;
    acc = 0;
    while (!acc) begin
      #1 acc = !pl_wait;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
  endtask

  task automatic send_pkt(input int id, input int len, input bit al, input bit a64, input bit bem);
    int nb;
    nb = (int'(al) + len + 1) / 2;
    exp_len[id] = len;
    n_sent++;
    for (int b = 0; b < nb; b++) begin
      logic [63:0] d;
      logic [7:0]  be;
      for (int ln = 0; ln < 2; ln++) begin
        int p, ix;
        p  = 2*b + ln;
        ix = p - int'(al);
        if (ix >= 0 && ix < len) begin
          d[ln*32 +: 32] = {id[15:0], ix[15:0]};
          be[ln*4 +: 4]  = bem ? (4'b0001 << (ix % 4)) : 4'hF;
        end else if (b == 0 && ln == 0 && al && bem) begin
          d[31:0] = 32'hDEAD_BEEF;  // R3 decoy with enables set
          be[3:0] = 4'hF;
        end else begin
          d[ln*32 +: 32] = 32'hBAD0_0000 | p;  // R4 disabled lane
          be[ln*4 +: 4]  = 4'h0;
        end
      end
      put_beat(b == 0, b == nb - 1, d, be, make_desc(a64, al));
    end
    @(negedge clk);
    pl_valid = 1'b0;
    if (al && (len % 2 == 1) && len >= 3) begin
      #1 chk(pl_wait == 1'b1, "R6 wait during flush", {63'h0, pl_wait}, 64'h1);
    end
  endtask

  initial begin
    int id;
    rst_n = 1'b0; pl_valid = 1'b0; pl_first = 1'b0; pl_last = 1'b0;
    pl_data = '0; pl_be = '0; pl_desc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(dw_valid == 1'b0, "R9 reset valid", {63'h0, dw_valid}, 64'h0);
    chk(pl_wait == 1'b0, "R9 reset wait", {63'h0, pl_wait}, 64'h0);
    // leave a DWORD in the holding register, then reset over it
    put_beat(1'b1, 1'b0, 64'h5555_0000_7777_0000, 8'hF0, make_desc(1'b1, 1'b1));
    @(negedge clk);
    pl_valid = 1'b0;
    #1 chk(dw_valid == 1'b0, "R9 lone held dword not sent", {63'h0, dw_valid}, 64'h0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(dw_valid == 1'b0, "R9 valid after reset", {63'h0, dw_valid}, 64'h0);
    chk(pl_wait == 1'b0, "R9 wait after reset", {63'h0, pl_wait}, 64'h0);
    id = 0;
    for (int rm = 0; rm < 4; rm++)
      for (int bem = 0; bem < 2; bem++)
        for (int a64 = 0; a64 < 2; a64++)
          for (int al = 0; al < 2; al++)
            for (int len = 1; len <= 7; len++) begin
              ready_mode = rm;
              send_pkt(id, len, al[0], a64[0], bem[0]);
              id++;
            end
    while (rx_pkt < n_sent) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(dw_valid == 1'b0, "R6 nothing after final beat", {63'h0, dw_valid}, 64'h0);
    chk(rx_pkt == n_sent, "R6 payload count", 64'(rx_pkt), 64'(n_sent));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule